// File: doc/BRIEF.md
# Branch Destination Trace Queue

This block keeps a short history of where the processor went after recent branches. Each time the processor side raises a branch pulse, it presents the low address bits of the first instruction fetched after that branch. The block pushes that address into a four-entry shifting queue and marks the entry valid. The newest branch always sits at the front of the queue, and the oldest entry drops off the far end.

Software reads the history one 32-bit word at a time through a single read strobe. Each word carries a valid flag in the top bit, three reserved bits that always read as zero, and the 28-bit captured address. A read returns the front entry and then pops it: the older entries move one place toward the front, and the vacated back slot becomes invalid. Repeated reads therefore walk back through older branches until an invalid word comes out.

There are two synchronous reset inputs, one for power-on and one for manual reset. Either of them clears every valid flag. The stored addresses are not touched by either reset, so a debugger can still recover them after a manual reset. The read word is registered and appears one cycle after the strobe.

Top module: `brdest_trace`

## Requirements
- R1: While either reset input (rst_por or rst_man, both synchronous and active-high) is high at a clock edge, all four valid flags and rd_data are cleared to zero. Branch and read inputs are ignored in that cycle. Stored addresses keep their values.
- R2: A branch pulse without a read puts br_addr into entry 0 with its valid flag set. Each entry k moves to entry k+1, and the old contents of entry 3 are discarded.
- R3: One cycle after a read strobe, rd_data holds the pre-read entry 0, formatted as bit 31 = its valid flag, bits 30..28 = 0, bits 27..0 = its address.
- R4: A read without a branch pops the queue. Entry k+1 moves to entry k, and entry 3 becomes invalid while its address is kept.
- R5: When a branch pulse and a read strobe arrive in the same cycle, the read returns the pre-branch entry 0. Afterwards entry 0 holds the new address as valid, and entries 1 to 3 are unchanged.
- R6: rd_data keeps its value in every cycle without a read strobe.
- R7: Bits 30..28 of rd_data are always 0.
- R8: A read of an invalid front entry returns bit 31 = 0.
- R9: After more than four branches without reads, four reads return the four newest addresses, newest first, and a fifth read returns an invalid word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por | input | 1 | Power-on reset, synchronous, active-high |
| rst_man | input | 1 | Manual reset, synchronous, active-high |
| br_pulse | input | 1 | A branch happened; capture br_addr this cycle |
| br_addr | input | 28 | Low bits of the first fetch address after the branch |
| rd_stb | input | 1 | Read strobe: return the front entry and pop it |
| rd_data | output | 32 | Registered read word: valid, reserved zeros, address |

## Verification
The embedded assertions check, on every clock, several facts:
- the reserved bits stay zero;
- the valid flags are clear after any reset;
- a branch lands in entry 0;
- the valid flags shift correctly for a pop and for a simultaneous push and pop;
- a read returns the pre-read front entry;
- rd_data holds still when there is no strobe.

Only the bench's scenarios can show the end-to-end history. These scenarios cover:
- the newest-first read order;
- the loss of the oldest entry after five branches;
- stored addresses surviving a manual reset;
- a branch during reset being dropped.

The bench compares these against its own model on every clock.

// File: rtl/brdest_trace.sv
module brdest_trace #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 28,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_por,
  input  logic              rst_man,
  input  logic              br_pulse,
  input  logic [ADDR_W-1:0] br_addr,
  input  logic              rd_stb,
  output logic [WORD_W-1:0] rd_data
);
  localparam int RSV_W = WORD_W - 1 - ADDR_W;

  logic              rst_any;
  logic [DEPTH-1:0]  vld;
  logic [ADDR_W-1:0] addr_q [DEPTH];

  assign rst_any = rst_por | rst_man;

  // Valid flags and read word: cleared by either reset.
  always_ff @(posedge clk) begin
    if (rst_any) begin
      vld     <= '0;
      rd_data <= '0;
    end else begin
      if (rd_stb) rd_data <= {vld[0], {RSV_W{1'b0}}, addr_q[0]};
      case ({br_pulse, rd_stb})
        2'b10: vld <= {vld[DEPTH-2:0], 1'b1};
        2'b01: vld <= {1'b0, vld[DEPTH-1:1]};
        2'b11: vld[0] <= 1'b1;
        default: ;
      endcase
    end
  end

  // Addresses: no reset, frozen while any reset is asserted.
  always_ff @(posedge clk) begin
    if (!rst_any) begin
      case ({br_pulse, rd_stb})
        2'b10: begin
          for (int k = DEPTH - 1; k > 0; k--) addr_q[k] <= addr_q[k-1];
          addr_q[0] <= br_addr;
        end
        2'b01: for (int k = 0; k < DEPTH - 1; k++) addr_q[k] <= addr_q[k+1];
        2'b11: addr_q[0] <= br_addr;
        default: ;
      endcase
    end
  end

  p_rsv_zero_r7: assert property (@(posedge clk) disable iff (rst_any)
    rd_data[WORD_W-2:ADDR_W] == '0);

  p_rst_clear_r1: assert property (@(posedge clk) disable iff (rst_any)
    $fell(rst_any) |-> (vld == '0 && rd_data == '0));

  p_push_r2: assert property (@(posedge clk) disable iff (rst_any)
    br_pulse |=> (vld[0] && addr_q[0] == $past(br_addr)));

  p_read_word_r3: assert property (@(posedge clk) disable iff (rst_any)
    rd_stb |=> (rd_data[WORD_W-1] == $past(vld[0]) &&
                rd_data[ADDR_W-1:0] == $past(addr_q[0])));

  p_pop_r4: assert property (@(posedge clk) disable iff (rst_any)
    (rd_stb && !br_pulse) |=> vld == {1'b0, $past(vld[DEPTH-1:1])});

  p_both_r5: assert property (@(posedge clk) disable iff (rst_any)
    (rd_stb && br_pulse) |=> vld == {$past(vld[DEPTH-1:1]), 1'b1});

  p_hold_r6: assert property (@(posedge clk) disable iff (rst_any)
    !rd_stb |=> $stable(rd_data));
endmodule

// File: tb/brdest_trace_tb.sv
module brdest_trace_tb;
  localparam int CLK_PERIOD = 10;
  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst_por = 1'b0, rst_man = 1'b0;
  logic        br_pulse = 1'b0, rd_stb = 1'b0;
  logic [27:0] br_addr = '0;
  logic [31:0] rd_data;

  int checks = 0, fails = 0, cycles = 0;

  // reference model
  logic [27:0] m_addr [D];
  bit          m_known [D];
  bit          m_vld [D];
  bit          m_rv = 1'b0;
  logic [27:0] m_ra = '0;
  bit          m_rknown = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brdest_trace u_dut (.clk(clk), .rst_por(rst_por), .rst_man(rst_man),
    .br_pulse(br_pulse), .br_addr(br_addr), .rd_stb(rd_stb), .rd_data(rd_data));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic model_edge();
    bit          v [D];
    logic [27:0] a [D];
    bit          kn [D];
    for (int i = 0; i < D; i++) begin v[i] = m_vld[i]; a[i] = m_addr[i]; kn[i] = m_known[i]; end
    if (rst_por || rst_man) begin
      for (int i = 0; i < D; i++) m_vld[i] = 0;
      m_rv = 0; m_ra = '0; m_rknown = 1;
      return;
    end
    if (rd_stb) begin
      m_rv = v[0]; m_ra = a[0]; m_rknown = kn[0];
      for (int i = 0; i < D - 1; i++) begin v[i] = v[i+1]; a[i] = a[i+1]; kn[i] = kn[i+1]; end
      v[D-1] = 0;
    end
    if (br_pulse) begin
      for (int i = D - 1; i > 0; i--) begin v[i] = v[i-1]; a[i] = a[i-1]; kn[i] = kn[i-1]; end
      v[0] = 1; a[0] = br_addr; kn[0] = 1;
    end
    for (int i = 0; i < D; i++) begin m_vld[i] = v[i]; m_addr[i] = a[i]; m_known[i] = kn[i]; end
  endtask

  task automatic compare(string tag);
    checks++;
    if (rd_data[31] !== m_rv || rd_data[30:28] !== 3'b000 ||
        (m_rknown && rd_data[27:0] !== m_ra)) begin
      fails++;
      $display("FAIL %s: actual %h expected valid=%0d rsv=0 addr=%h (addr %s)",
               tag, rd_data, m_rv, m_ra, m_rknown ? "known" : "unknown");
    end
  endtask

  task automatic step(string tag, bit b, logic [27:0] a, bit r, bit rp = 0, bit rm = 0);
    br_pulse = b; br_addr = a; rd_stb = r; rst_por = rp; rst_man = rm;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    for (int i = 0; i < D; i++) begin m_vld[i] = 0; m_known[i] = 0; m_addr[i] = '0; end
    @(negedge clk);
    step("R1 por", 0, '0, 0, 1, 0);
    step("R1 por", 0, '0, 0, 1, 0);
    // R8: empty queue
    step("R8 empty read", 0, '0, 1);
    step("R6 hold", 0, '0, 0);
    // R2/R3/R4: three pushes then walk back
    step("R2 push", 1, 28'h000_0A1, 0);
    step("R2 push", 1, 28'hFFF_FFFF, 0);
    step("R2 push", 1, 28'h123_4567, 0);
    step("R6 hold", 0, '0, 0);
    step("R3 read newest", 0, '0, 1);
    step("R4 pop", 0, '0, 1);
    step("R4 pop", 0, '0, 1);
    step("R4 vacated invalid", 0, '0, 1);
    step("R6 hold", 0, '0, 0);
    // R9: five pushes, oldest lost
    for (int i = 0; i < 5; i++) step("R9 push", 1, 28'h100_0000 + 28'(i * 17), 0);
    for (int i = 0; i < 5; i++) step("R9 read", 0, '0, 1);
    // R5: simultaneous branch and read
    step("R2 push", 1, 28'hAAA_AAAA, 0);
    step("R2 push", 1, 28'h555_5555, 0);
    step("R5 both", 1, 28'h0F0_F0F0, 1);
    step("R5 both again", 1, 28'h00C_0FFE, 1);
    for (int i = 0; i < 4; i++) step("R5 drain", 0, '0, 1);
    // R1: manual reset keeps addresses; branch/read during reset ignored
    step("R2 push", 1, 28'h0DE_ADBE, 0);
    step("R2 push", 1, 28'h0BE_EF01, 0);
    step("R3 read", 0, '0, 1);
    step("R1 manual reset", 1, 28'h777_7777, 1, 0, 1);
    for (int i = 0; i < 4; i++) step("R1 after reset", 0, '0, 1);
    // R1 addresses retained: push one then read back the retained second entry
    step("R2 push", 1, 28'h246_8ACE, 0);
    step("R1 push post", 0, '0, 1);
    step("R1 retained invalid", 0, '0, 1);
    // R7 on mixed traffic
    for (int i = 0; i < 20; i++)
      step("R7 mixed", (i % 3) != 0, 28'(32'hFFFF_FFF0 + i), (i % 2) == 0);
    step("R1 por again", 0, '0, 0, 1, 0);
    step("R8 read after por", 0, '0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule